// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Unit

This block collects interrupt requests from a row of sources sitting on an 8-bit processor bus and presents them to the processor on one shared active-low request line. Priority is not worked out by a central encoder: each slot passes an enable to the slot behind it, and it withholds that enable while it has a request waiting or is being serviced. The slot nearest the head of the chain, whose enable is permanently active, always has the highest priority.

The processor acknowledges by pulling its opcode-fetch strobe and its I/O request strobe low together. The first coincident sample counts as one acknowledge. The eligible slot nearest the head latches its 8-bit vector, with bit 0 cleared so that table entries stay word aligned, and drives it until the strobes are released. The unit also forms the 16-bit table pointer as the processor's page byte (high) followed by the vector (low). A return-from-interrupt pulse, which the processor's decoder supplies, ends service for the highest-priority slot that is in service. This allows service of a lower slot to be nested under a higher one. The vector is a bus drive that lasts as long as the acknowledge strobes are held. The acknowledge itself is the handshake, so the vector path has no ready or back-pressure.

Top module: `vic_chain`

## Requirements
- R1: After reset, irq_n is 1, vec_oe is 0, vec_out is 8'h00 and chain_eo is 1.
- R2: A one-cycle pulse on src_req[i] makes slot i pending. irq_n goes to 0 in the following cycle if every slot ahead of i is idle and slot i is not in service.
- R3: An acknowledge is taken when opfetch_n and ioreq_n are both sampled 0. Only the first such sample counts, and a single low strobe does nothing. vec_oe rises one cycle later, vec_out holds steady while both strobes stay low, and vec_oe falls in the cycle after they are released.
- R4: If several slots are pending, the acknowledge is answered by the pending slot with the lowest index. Slot 0 sits at the head of the chain.
- R5: The answering slot leaves the pending state and enters service. While it is in service, slots with a higher index neither pull irq_n low nor answer an acknowledge.
- R6: A pulse on reti_pulse ends service for the in-service slot with the lowest index. A pending slot that was blocked behind it then pulls irq_n low again.
- R7: While a slot is in service, a pending slot with a lower index can still be acknowledged, so service nests.
- R8: The driven vector is the slot's configured byte from slot_vec[8*i+7:8*i] with bit 0 forced to 0.
- R9: While vec_oe is 1, tbl_ptr equals {page_hi, vec_out}.
- R10: Further request pulses to a slot that is already pending are absorbed, and the slot answers only one acknowledge.
- R11: chain_eo is 1 exactly when no slot is pending or in service.
- R12: An acknowledge that finds no eligible slot leaves vec_oe at 0 and changes no slot state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | N | One request pulse per slot, index 0 is highest priority |
| opfetch_n | input | 1 | Processor opcode-fetch strobe, active low |
| ioreq_n | input | 1 | Processor I/O request strobe, active low |
| reti_pulse | input | 1 | Return-from-interrupt decoded, one cycle |
| slot_vec | input | 8*N | Vector byte per slot, slot i in bits 8*i+7:8*i |
| page_hi | input | 8 | Processor page register, high byte of the table pointer |
| irq_n | output | 1 | Common interrupt request, active low |
| vec_oe | output | 1 | Vector drive enable onto the data bus |
| vec_out | output | 8 | Vector byte (0 when not driving) |
| tbl_ptr | output | 16 | Service table pointer {page_hi, vec_out} |
| chain_eo | output | 1 | Enable out of the last slot, for cascading |

## Verification
On every cycle the assertions check four things: a vector drive only follows a coincident strobe sample, the driven byte has bit 0 clear and does not change while it is driven, a new drive is only ever preceded by an active request, and an idle chain never holds the request line low. Which slot answers, and the order in which simultaneous requests come out, depend on a history of pulses, acknowledges and returns. Only the bench scenarios can show these, along with nesting, absorption of repeated requests and the strobe release timing.

// File: rtl/vic_chain_pkg.sv
package vic_chain_pkg;
  localparam int VEC_W = 8;
  localparam int PTR_W = 2 * VEC_W;
  typedef logic [VEC_W-1:0] vec_t;

  // Table entries are two bytes wide, so the low bit never selects.
  function automatic vec_t align_vec(input vec_t v);
    return {v[VEC_W-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/vic_slot.sv
module vic_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ien,
  input  logic svc_in,
  input  logic ack_evt,
  input  logic reti_evt,
  output logic eo,
  output logic win,
  output logic irq,
  output logic in_svc
);
  logic pend_q;
  logic svc_q;

  // Eligible: reached by the chain, waiting, and not already being served.
  assign irq    = ien & pend_q & ~svc_q;
  assign win    = ack_evt & irq;
  // A waiting or busy slot cuts the chain for everything behind it.
  assign eo     = ien & ~pend_q & ~svc_q;
  assign in_svc = svc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      if (win)      pend_q <= 1'b0;
      else if (req) pend_q <= 1'b1;

      if (win)                            svc_q <= 1'b1;
      else if (reti_evt & svc_in & svc_q) svc_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vic_ack_detect.sv
module vic_ack_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic opfetch_n,
  input  logic ioreq_n,
  output logic ack_lvl,
  output logic ack_evt
);
  logic ack_q;

  assign ack_lvl = ~opfetch_n & ~ioreq_n;
  assign ack_evt = ack_lvl & ~ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_lvl;
  end
endmodule

// File: rtl/vic_vec_sel.sv
module vic_vec_sel
  import vic_chain_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]       win,
  input  logic [N*VEC_W-1:0] cfg,
  output logic               hit,
  output vec_t               vec
);
  vec_t raw;

  // win is one-hot at most, so an OR of the gated bytes selects.
  always_comb begin
    raw = '0;
    for (int i = 0; i < N; i++) begin
      if (win[i]) raw = raw | cfg[i*VEC_W +: VEC_W];
    end
  end

  assign hit = |win;
  assign vec = align_vec(raw);
endmodule

// File: rtl/vic_chain.sv
module vic_chain
  import vic_chain_pkg::*;
#(
  parameter int N = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       src_req,
  input  logic               opfetch_n,
  input  logic               ioreq_n,
  input  logic               reti_pulse,
  input  logic [N*VEC_W-1:0] slot_vec,
  input  logic [VEC_W-1:0]   page_hi,
  output logic               irq_n,
  output logic               vec_oe,
  output logic [VEC_W-1:0]   vec_out,
  output logic [PTR_W-1:0]   tbl_ptr,
  output logic               chain_eo
);
  logic         ack_lvl;
  logic         ack_evt;
  logic [N:0]   en_chain;
  logic [N-1:0] svc_chain;
  logic [N-1:0] win;
  logic [N-1:0] slot_irq;
  logic [N-1:0] in_svc;
  logic         hit;
  vec_t         sel_vec;
  vec_t         vec_q;
  logic         drive_q;

  vic_ack_detect u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .opfetch_n (opfetch_n),
    .ioreq_n   (ioreq_n),
    .ack_lvl   (ack_lvl),
    .ack_evt   (ack_evt)
  );

  // Head of both chains is tied active.
  assign en_chain[0]  = 1'b1;
  assign svc_chain[0] = 1'b1;

  for (genvar i = 0; i < N; i++) begin : g_slot
    vic_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (src_req[i]),
      .ien      (en_chain[i]),
      .svc_in   (svc_chain[i]),
      .ack_evt  (ack_evt),
      .reti_evt (reti_pulse),
      .eo       (en_chain[i+1]),
      .win      (win[i]),
      .irq      (slot_irq[i]),
      .in_svc   (in_svc[i])
    );
    // Return chain ignores pending state: only service blocks it.
    if (i < N-1) begin : g_svc
      assign svc_chain[i+1] = svc_chain[i] & ~in_svc[i];
    end
  end

  vic_vec_sel #(.N(N)) u_sel (
    .win (win),
    .cfg (slot_vec),
    .hit (hit),
    .vec (sel_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      if (!ack_lvl)           drive_q <= 1'b0;
      else if (ack_evt & hit) drive_q <= 1'b1;
      if (ack_evt & hit)      vec_q   <= sel_vec;
    end
  end

  assign irq_n    = ~|slot_irq;
  assign vec_oe   = drive_q;
  assign vec_out  = drive_q ? vec_q : '0;
  assign tbl_ptr  = {page_hi, vec_out};
  assign chain_eo = en_chain[N];
endmodule

// File: rtl/vic_chain_chk.sv
module vic_chain_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       opfetch_n,
  input logic       ioreq_n,
  input logic       irq_n,
  input logic       vec_oe,
  input logic [7:0] vec_out,
  input logic       chain_eo
);
  AST_DRIVE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> $past(!opfetch_n && !ioreq_n)); // R3

  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_oe && $past(vec_oe)) |-> $stable(vec_out)); // R3

  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> !vec_out[0]); // R8

  AST_DRIVE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_oe) |-> $past(!irq_n)); // R5

  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    chain_eo |-> irq_n); // R11
endmodule

bind vic_chain vic_chain_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .opfetch_n (opfetch_n),
  .ioreq_n   (ioreq_n),
  .irq_n     (irq_n),
  .vec_oe    (vec_oe),
  .vec_out   (vec_out),
  .chain_eo  (chain_eo)
);

// File: tb/vic_chain_bench.sv
module vic_chain_bench;
  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_req = '0;
  logic          opfetch_n = 1'b1;
  logic          ioreq_n = 1'b1;
  logic          reti_pulse = 1'b0;
  logic [N*8-1:0] slot_vec = {8'h47, 8'h36, 8'h25, 8'h10};
  logic [7:0]    page_hi = 8'h3C;
  logic          irq_n;
  logic          vec_oe;
  logic [7:0]    vec_out;
  logic [15:0]   tbl_ptr;
  logic          chain_eo;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  logic oe_prev = 1'b0;

  always #4 clk = ~clk;

  vic_chain #(.N(N)) u_vic_chain (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .opfetch_n(opfetch_n),
    .ioreq_n(ioreq_n), .reti_pulse(reti_pulse), .slot_vec(slot_vec),
    .page_hi(page_hi), .irq_n(irq_n), .vec_oe(vec_oe), .vec_out(vec_out),
    .tbl_ptr(tbl_ptr), .chain_eo(chain_eo)
  );

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] vec_of(input int s);
    return slot_vec[s*8 +: 8] & 8'hFE; // R8: bit 0 cleared
  endfunction

  // Monitor: pops one expected vector on each new drive.
  always @(negedge clk) begin
    if (rst_n && vec_oe && !oe_prev) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected vector drive", {8'h00, vec_out}, 16'h0000);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk("R4 R8 vector order", {8'h00, vec_out}, {8'h00, e});
        chk("R9 table pointer", tbl_ptr, {page_hi, e});
      end
    end
    oe_prev = vec_oe;
  end

  task automatic pulse_req(input logic [N-1:0] m);
    @(negedge clk) src_req = m;
    @(negedge clk) src_req = '0;
  endtask

  task automatic reti();
    @(negedge clk) reti_pulse = 1'b1;
    @(negedge clk) reti_pulse = 1'b0;
  endtask

  // Driver: slot < 0 means no slot should answer.
  task automatic ack(input int slot, input string rq);
    if (slot >= 0) exp_q.push_back(vec_of(slot));
    @(negedge clk) begin opfetch_n = 1'b0; ioreq_n = 1'b0; end
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk({rq, " R3 drive held"}, {15'h0, vec_oe}, {15'h0, (slot >= 0)});
    opfetch_n = 1'b1; ioreq_n = 1'b1;
    @(negedge clk);
    chk({rq, " R3 drive released"}, {15'h0, vec_oe}, 16'h0000);
    chk({rq, " scoreboard drained"}, 16'(exp_q.size()), 16'h0000);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_n", {15'h0, irq_n}, 16'h0001);
    chk("R1 vec_oe", {15'h0, vec_oe}, 16'h0000);
    chk("R1 vec_out", {8'h0, vec_out}, 16'h0000);
    chk("R1 chain_eo", {15'h0, chain_eo}, 16'h0001);

    // R2 R4 R5 R6: slots 1 and 3
    pulse_req(4'b1010);
    chk("R2 irq asserted", {15'h0, irq_n}, 16'h0000);
    chk("R11 chain busy", {15'h0, chain_eo}, 16'h0000);
    ack(1, "R4 slot1 first");
    chk("R5 lower blocked irq", {15'h0, irq_n}, 16'h0001);
    ack(-1, "R5 lower blocked ack");
    reti();
    chk("R6 lower released", {15'h0, irq_n}, 16'h0000);
    ack(3, "R6 slot3 after return");
    reti();
    chk("R11 chain idle", {15'h0, chain_eo}, 16'h0001);
    chk("R6 irq idle", {15'h0, irq_n}, 16'h0001);

    // R4 simultaneous requests on all slots, chain order
    page_hi = 8'hA5; // R9 different page
    pulse_req(4'b1111);
    for (int s = 0; s < N; s++) begin
      ack(s, "R4 chain order");
      reti();
    end
    chk("R4 all served", {15'h0, irq_n}, 16'h0001);

    // R7 nesting
    pulse_req(4'b0100);
    ack(2, "R7 slot2");
    pulse_req(4'b0001);
    chk("R7 higher requests", {15'h0, irq_n}, 16'h0000);
    ack(0, "R7 nested slot0");
    reti();
    pulse_req(4'b1000);
    chk("R7 slot2 still blocks", {15'h0, irq_n}, 16'h0001);
    reti();
    chk("R6 slot3 released", {15'h0, irq_n}, 16'h0000);
    ack(3, "R7 slot3 after unwind");
    reti();

    // R10 repeated requests absorbed
    pulse_req(4'b0010);
    pulse_req(4'b0010);
    ack(1, "R10 single answer");
    reti();
    ack(-1, "R10 no second answer");
    chk("R10 irq idle", {15'h0, irq_n}, 16'h0001);

    // R12 acknowledge with nothing pending
    ack(-1, "R12 empty chain");
    chk("R12 chain idle", {15'h0, chain_eo}, 16'h0001);

    // R3 a single strobe is not an acknowledge
    pulse_req(4'b0001);
    @(negedge clk) opfetch_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R3 fetch strobe alone", {15'h0, vec_oe}, 16'h0000);
    opfetch_n = 1'b1;
    @(negedge clk) ioreq_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R3 io strobe alone", {15'h0, vec_oe}, 16'h0000);
    ioreq_n = 1'b1;
    @(negedge clk);
    chk("R3 still pending", {15'h0, irq_n}, 16'h0000);
    ack(0, "R3 full acknowledge");
    reti();
    chk("R11 final idle", {15'h0, chain_eo}, 16'h0001);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule